// File: doc/BRIEF.md
# Presettable Synchronous Binary Counter

This block is a small synchronous up-counter with a parallel preset path. Every change happens on the rising clock edge: it can load a preset word, count up by one, or hold. The one exception is the clear, which can be built to act without the clock. Two enable inputs gate counting. Only one of them, `enable_t`, also qualifies the carry output. This lets a chain of stages share one `enable_p` while each stage's `enable_t` is fed from the previous stage's carry.

The clear input is active low. The parameter `ASYNC_RESET` selects its behaviour when the design is elaborated. With 1, the count is zeroed as soon as `clear_n` falls. With 0, the count is zeroed at the next rising edge. Among the controls, clear wins over load, load wins over count, and count wins over hold. The carry output is taken combinationally from the registered count and `enable_t`. A following stage therefore sees it in the same cycle, and a cascade of counters behaves as one wide synchronous counter.

Top module: `sync_bin_counter`

## Requirements
- R1: With `ASYNC_RESET`=0, `count` changes only at a rising edge of `clk`. Input changes between edges leave `count` unchanged until the next edge.
- R2: If `clear_n` is high and `load_n` is low at a rising edge, `count` takes the value of `preset`, with bit 0 as the least significant bit. No counting happens while `load_n` stays low.
- R3: If `clear_n`, `load_n`, `enable_p` and `enable_t` are all high at a rising edge, `count` increases by one.
- R4: If `clear_n` and `load_n` are high and either `enable_p` or `enable_t` is low at a rising edge, `count` keeps its value.
- R5: The count runs in plain binary order and wraps from all ones (15) back to 0.
- R6: With `ASYNC_RESET`=1, a low `clear_n` zeroes `count` at once, with no clock edge needed. With `ASYNC_RESET`=0, it zeroes `count` at the next rising edge.
- R7: A low `clear_n` overrides a low `load_n`: the result is zero, not the preset value.
- R8: `carry` is high exactly when `enable_t` is high and `count` is all ones. `enable_p` has no effect on it, including while the count is held at all ones.
- R9: Two instances cascaded form an 8-bit counter that wraps from 255 to 0 without losing a cycle. In the cascade, the low stage's `carry` drives the high stage's `enable_t`, and `enable_p`, `load_n` and `clear_n` are shared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge active |
| clear_n | input | 1 | Active-low clear (asynchronous or synchronous, set by `ASYNC_RESET`) |
| load_n | input | 1 | Active-low synchronous parallel load |
| enable_p | input | 1 | Count enable that does not affect the carry |
| enable_t | input | 1 | Count enable that also gates the carry |
| preset | input | WIDTH (4) | Parallel load value, bit 0 least significant |
| count | output | WIDTH (4) | Registered count value |
| carry | output | 1 | High when `enable_t` is high and `count` is all ones |

## Verification
The only state in this block is the count register, and it is exposed directly on `count`. A wrong next-state decision therefore shows on the port one edge after the faulty control combination, whether the fault is a misplaced priority, an increment taken while held, or a missed load. A fault in the carry path first shows in the high stage of the cascade. It appears as a high byte that moves at the wrong low-nibble boundary, seen at the edge after the low stage reaches all ones. A clear of the wrong kind shows within the same clock period: in asynchronous mode the output must already be zero before the next edge arrives.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
  // Operation chosen for the next rising edge, listed in priority order
  typedef enum logic [1:0] {
    OP_CLEAR = 2'd0,
    OP_LOAD  = 2'd1,
    OP_COUNT = 2'd2,
    OP_HOLD  = 2'd3
  } sbc_op_e;
endpackage

// File: rtl/sbc_ctrl.sv
module sbc_ctrl
  import sbc_pkg::*;
(
  input  logic    clear_n,
  input  logic    load_n,
  input  logic    enable_p,
  input  logic    enable_t,
  output sbc_op_e op
);
  always_comb begin
    if (!clear_n)                  op = OP_CLEAR;
    else if (!load_n)              op = OP_LOAD;
    else if (enable_p && enable_t) op = OP_COUNT;
    else                           op = OP_HOLD;
  end
endmodule

// File: rtl/sbc_state.sv
module sbc_state
  import sbc_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter bit ASYNC_RESET = 1'b1
) (
  input  logic             clk,
  input  logic             clear_n,
  input  sbc_op_e          op,
  input  logic [WIDTH-1:0] preset,
  output logic [WIDTH-1:0] q
);
  localparam logic [WIDTH-1:0] STEP = WIDTH'(1);

  logic [WIDTH-1:0] q_next;

  always_comb begin
    unique case (op)
      OP_CLEAR: q_next = '0;
      OP_LOAD:  q_next = preset;
      OP_COUNT: q_next = q + STEP;
      default:  q_next = q;
    endcase
  end

  generate
    if (ASYNC_RESET) begin : g_async_clear
      always_ff @(posedge clk or negedge clear_n) begin
        if (!clear_n) q <= '0;
        else          q <= q_next;
      end
    end else begin : g_sync_clear
      always_ff @(posedge clk) begin
        q <= q_next;
      end
    end
  endgenerate
endmodule

// File: rtl/sbc_carry.sv
module sbc_carry #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] q,
  input  logic             enable_t,
  output logic             carry
);
  always_comb carry = enable_t & (&q);
endmodule

// File: rtl/sync_bin_counter.sv
module sync_bin_counter
  import sbc_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter bit ASYNC_RESET = 1'b1
) (
  input  logic             clk,
  input  logic             clear_n,
  input  logic             load_n,
  input  logic             enable_p,
  input  logic             enable_t,
  input  logic [WIDTH-1:0] preset,
  output logic [WIDTH-1:0] count,
  output logic             carry
);
  sbc_op_e op;

  sbc_ctrl u_ctrl (
    .clear_n  (clear_n),
    .load_n   (load_n),
    .enable_p (enable_p),
    .enable_t (enable_t),
    .op       (op)
  );

  sbc_state #(.WIDTH(WIDTH), .ASYNC_RESET(ASYNC_RESET)) u_state (
    .clk     (clk),
    .clear_n (clear_n),
    .op      (op),
    .preset  (preset),
    .q       (count)
  );

  sbc_carry #(.WIDTH(WIDTH)) u_carry (
    .q        (count),
    .enable_t (enable_t),
    .carry    (carry)
  );
endmodule

// File: rtl/sbc_checker.sv
module sbc_checker #(
  parameter int WIDTH       = 4,
  parameter bit ASYNC_RESET = 1'b1
) (
  input logic             clk,
  input logic             clear_n,
  input logic             load_n,
  input logic             enable_p,
  input logic             enable_t,
  input logic [WIDTH-1:0] preset,
  input logic [WIDTH-1:0] count,
  input logic             carry
);
  localparam logic [WIDTH-1:0] ONES = '1;
  localparam logic [WIDTH-1:0] STEP = WIDTH'(1);

  // Armed once a clear has been seen, so the count is known from then on
  logic armed = 1'b0;
  always_ff @(posedge clk) if (!clear_n) armed <= 1'b1;

  a_r3_increment: assert property (@(posedge clk) disable iff (!armed)
    (clear_n && load_n && enable_p && enable_t) |=> (!clear_n || count == $past(count) + STEP));

  a_r5_wrap: assert property (@(posedge clk) disable iff (!armed)
    (clear_n && load_n && enable_p && enable_t && count == ONES) |=> (!clear_n || count == '0));

  a_r2_load: assert property (@(posedge clk) disable iff (!armed)
    (clear_n && !load_n) |=> (!clear_n || count == $past(preset)));

  a_r4_hold: assert property (@(posedge clk) disable iff (!armed)
    (clear_n && load_n && !(enable_p && enable_t)) |=> (!clear_n || $stable(count)));

  a_r7_clear_over_load: assert property (@(posedge clk) disable iff (!armed)
    (!clear_n && !load_n) |=> (count == '0));

  a_r8_carry_needs_state: assert property (@(posedge clk) disable iff (!armed)
    carry |-> (enable_t && count == ONES));

  a_r8_carry_present: assert property (@(posedge clk) disable iff (!armed)
    (enable_t && count == ONES) |-> carry);

  generate
    if (ASYNC_RESET) begin : g_chk_async
      a_r6_async_clear: assert property (@(posedge clk) disable iff (!armed)
        !clear_n |-> (count == '0));
    end else begin : g_chk_sync
      a_r6_sync_clear: assert property (@(posedge clk) disable iff (!armed)
        !clear_n |=> (count == '0));
    end
  endgenerate
endmodule

bind sync_bin_counter sbc_checker #(.WIDTH(WIDTH), .ASYNC_RESET(ASYNC_RESET)) u_sbc_checker (
  .clk      (clk),
  .clear_n  (clear_n),
  .load_n   (load_n),
  .enable_p (enable_p),
  .enable_t (enable_t),
  .preset   (preset),
  .count    (count),
  .carry    (carry)
);

// File: tb/sync_bin_counter_bench.sv
module sync_bin_counter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic       clk = 1'b0;
  logic       clear_n = 1'b0;
  logic       load_n = 1'b1;
  logic       enable_p = 1'b0;
  logic       enable_t = 1'b0;
  logic [7:0] preset8 = 8'h00;

  logic [3:0] s_lo, s_hi, a_lo, a_hi;
  logic       s_lo_c, s_hi_c, a_lo_c, a_hi_c;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  int exp_s = 0;
  int exp_a = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Synchronous-clear cascade
  sync_bin_counter #(.WIDTH(4), .ASYNC_RESET(1'b0)) u_sync_bin_counter (
    .clk(clk), .clear_n(clear_n), .load_n(load_n), .enable_p(enable_p),
    .enable_t(enable_t), .preset(preset8[3:0]), .count(s_lo), .carry(s_lo_c));
  sync_bin_counter #(.WIDTH(4), .ASYNC_RESET(1'b0)) u_sync_hi (
    .clk(clk), .clear_n(clear_n), .load_n(load_n), .enable_p(enable_p),
    .enable_t(s_lo_c), .preset(preset8[7:4]), .count(s_hi), .carry(s_hi_c));

  // Asynchronous-clear cascade
  sync_bin_counter #(.WIDTH(4), .ASYNC_RESET(1'b1)) u_async_lo (
    .clk(clk), .clear_n(clear_n), .load_n(load_n), .enable_p(enable_p),
    .enable_t(enable_t), .preset(preset8[3:0]), .count(a_lo), .carry(a_lo_c));
  sync_bin_counter #(.WIDTH(4), .ASYNC_RESET(1'b1)) u_async_hi (
    .clk(clk), .clear_n(clear_n), .load_n(load_n), .enable_p(enable_p),
    .enable_t(a_lo_c), .preset(preset8[7:4]), .count(a_hi), .carry(a_hi_c));

  function automatic int next_val(int cur);
    if (!clear_n)                  return 0;
    else if (!load_n)              return int'(preset8);
    else if (enable_p && enable_t) return (cur + 1) % 256;
    else                           return cur;
  endfunction

  task automatic check(string tag, int act, int expv);
    tests++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic check_all(string tag);
    check({tag, " sync count"},  int'({s_hi, s_lo}), exp_s);
    check({tag, " async count"}, int'({a_hi, a_lo}), exp_a);
    check({tag, " sync carry (R8)"},  int'(s_hi_c), int'(enable_t && exp_s == 255));
    check({tag, " async carry (R8)"}, int'(a_hi_c), int'(enable_t && exp_a == 255));
  endtask

  task automatic tick(string tag);
    @(posedge clk);
    exp_s = next_val(exp_s);
    exp_a = next_val(exp_a);
    @(negedge clk);
    check_all(tag);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R6: reset state after clear in both modes
    repeat (2) tick("R6 clear");
    clear_n = 1'b1;
    tick("R4 idle hold");

    // R3: count with both enables
    enable_p = 1'b1; enable_t = 1'b1;
    for (int i = 0; i < 20; i++) tick("R3 count");

    // R4: hold with enable_p low, then with enable_t low
    enable_p = 1'b0;
    repeat (3) tick("R4 hold ep low");
    enable_p = 1'b1; enable_t = 1'b0;
    repeat (3) tick("R4 hold et low");

    // R8: held at all ones with enable_p low keeps carry; enable_t low drops it
    load_n = 1'b0; preset8 = 8'hFF;
    tick("R2 load FF");
    load_n = 1'b1; enable_p = 1'b0; enable_t = 1'b1;
    repeat (2) tick("R8 carry with ep low");
    enable_t = 1'b0;
    #1 check("R8 carry drops with et", int'(s_hi_c), 0);
    tick("R8 et low");

    // R1: load_n changes mid-cycle; no change before the edge
    load_n = 1'b0; preset8 = 8'hEC;
    #2 check("R1 no change between edges", int'({s_hi, s_lo}), exp_s);
    tick("R2 load EC");
    // R2: counting suppressed while load_n low
    enable_p = 1'b1; enable_t = 1'b1;
    repeat (3) tick("R2 load held low");

    // R5 / R9: wrap of low nibble into high nibble, then 255 to 0
    load_n = 1'b0; preset8 = 8'hF0;
    tick("R2 load F0");
    load_n = 1'b1;
    for (int i = 0; i < 20; i++) tick("R9 cascade R5 wrap");
    load_n = 1'b0; preset8 = 8'hFD;
    tick("R2 load FD");
    load_n = 1'b1;
    for (int i = 0; i < 6; i++) tick("R9 wrap 255 to 0");

    // R6: async clear takes effect at once, sync waits for the edge
    load_n = 1'b0; preset8 = 8'h5A;
    tick("R2 load 5A");
    load_n = 1'b1;
    clear_n = 1'b0;
    #1;
    exp_a = 0;
    check("R6 async immediate", int'({a_hi, a_lo}), 0);
    check("R6 sync waits for edge", int'({s_hi, s_lo}), exp_s);
    tick("R6 clear edge");
    clear_n = 1'b1;
    tick("R3 count after clear");

    // R7: clear overrides load in both modes
    load_n = 1'b0; preset8 = 8'hA7;
    tick("R2 load A7");
    clear_n = 1'b0;
    #1 exp_a = 0;
    tick("R7 clear over load");
    clear_n = 1'b1; load_n = 1'b1;
    repeat (3) tick("R3 final count");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule